// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

This block is a periodic tick source with a small bank of independent down-counting channels. Each channel has its own period register and control register. The control register selects an operation (load, run or hold) and a count rate that is derived from the core clock through enable pulses. While a channel runs, it steps down once per enabled tick. When it completes a period, it reloads its period value and raises an interrupt flag. Software may read the live count at any time. The time elapsed inside the current period is the period value minus the count, in ticks.

All channels share one interrupt register set. Raw event flags are sticky, a mask selects which flags reach the interrupt line, and a masked view shows the pending enabled sources. Writing ones to the acknowledge register clears flags. The register port is a single-cycle write strobe and a read strobe, and read data returns one cycle after the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-high reset, every count, period, control, mask and raw flag is zero, irq_o is low, and a read returns 0.
- R2: A control write with operation code 1 (load; control bits [1:0]) copies the channel's period value into its count in that cycle and does not count. The count stays there while the stored operation is load.
- R3: With operation code 2 (run), the count decreases by one on each enabled tick. A read of the count register (channel offset 2) returns the value held before the read cycle's edge.
- R4: When a running channel ticks with a count of 1 or 0, the count reloads the period value, so a period lasts exactly "period value" ticks and a read after the wrap returns a larger value than the read before it.
- R5: Operation codes 0 and 3 hold the count at its current value. A write that selects hold takes effect from the following edge.
- R6: Control bits [3:2] select the rate. Code k gives one tick every 2^(k*PS_SHIFT) core cycles, so code 0 counts every cycle.
- R7: A channel's raw flag (bit n of the raw register, global offset 1) is set on the edge at which that channel reloads and stays set until acknowledged.
- R8: Writing the acknowledge register (global offset 3) clears raw bits written as 1 and leaves bits written as 0 unchanged. When an acknowledge and a new event for a bit fall in the same cycle, the bit stays set.
- R9: The masked register (global offset 2) reads raw AND mask (mask at global offset 0), and irq_o is the OR of the masked bits.
- R10: Channel n uses addresses 4n+0 (period), 4n+1 (control, read back as {rate, op}) and 4n+2 (count). Global registers start at 4*NUM_TMR. A read strobe gives rd_valid_o and rdata_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | OR of masked interrupt flags |

## Verification
The case that matters most is a software acknowledge that arrives on the same edge as a reload event. The bench provokes it by running a channel with a short period and placing the acknowledge write exactly on the reload edge, which it counts from the run command. It then reads the raw register and expects the flag to remain set, and a later acknowledge with no competing event must clear it. A second coincidence is a control write selecting hold on an edge where the counter wraps. The bench expects the reload to complete before the count freezes.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int FREQ_W   = 2;
  localparam int NUM_FREQ = 1 << FREQ_W;
  localparam int OP_W     = 2;
  localparam int CTRL_W   = OP_W + FREQ_W;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_STOP = 2'd3
  } tmr_op_e;

  // offsets inside a channel window
  localparam logic [1:0] OFS_DIV   = 2'd0;
  localparam logic [1:0] OFS_CTRL  = 2'd1;
  localparam logic [1:0] OFS_COUNT = 2'd2;
  // offsets inside the global window
  localparam logic [1:0] GLB_MASK   = 2'd0;
  localparam logic [1:0] GLB_RAW    = 2'd1;
  localparam logic [1:0] GLB_MASKED = 2'd2;
  localparam logic [1:0] GLB_ACK    = 2'd3;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
  import tt_pkg::*;
#(
  parameter int PS_SHIFT = 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_FREQ-1:0] tick_o
);
  localparam int PRE_W = PS_SHIFT * (NUM_FREQ - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_FREQ; k++) begin : g_tap
    localparam logic [PRE_W-1:0] MSK = PRE_W'((64'd1 << (k * PS_SHIFT)) - 64'd1);
    assign tick_o[k] = ((pre_q & MSK) == '0);
  end

  // R6: the fastest rate is enabled on every cycle
  assert_base_rate_R6: assert property (@(posedge clk) disable iff (rst) tick_o[0]);
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                div_wr_i,
  input  logic [CNT_W-1:0]    div_wdata_i,
  input  logic                ctrl_wr_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  input  logic [NUM_FREQ-1:0] tick_i,
  output logic [CNT_W-1:0]    div_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                evt_o
);
  tmr_op_e           op_q;
  logic [FREQ_W-1:0] freq_q;
  logic [CNT_W-1:0]  div_q;
  logic [CNT_W-1:0]  count_q;
  tmr_op_e           wr_op;
  logic              load_pulse;
  logic              running;
  logic              tick_sel;
  logic              at_end;

  assign wr_op      = tmr_op_e'(ctrl_wdata_i[OP_W-1:0]);
  assign load_pulse = ctrl_wr_i && (wr_op == OP_LOAD);
  assign running    = (op_q == OP_RUN);
  assign tick_sel   = tick_i[freq_q];
  assign at_end     = (count_q <= CNT_W'(1));
  assign evt_o      = !load_pulse && running && tick_sel && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      op_q   <= OP_HOLD;
      freq_q <= '0;
    end else begin
      if (div_wr_i) div_q <= div_wdata_i;
      if (ctrl_wr_i) begin
        op_q   <= wr_op;
        freq_q <= ctrl_wdata_i[CTRL_W-1:OP_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        count_q <= '0;
    else if (load_pulse)            count_q <= div_q;
    else if (running && tick_sel)   count_q <= at_end ? div_q : count_q - 1'b1;
  end

  assign div_o   = div_q;
  assign ctrl_o  = {freq_q, op_q};
  assign count_o = count_q;

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> (count_q == $past(div_q)));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (running && tick_sel && !at_end && !load_pulse) |=> (count_q == $past(count_q) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> (count_q == $past(div_q)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!running && !load_pulse) |=> $stable(count_q));
endmodule

// File: rtl/tt_irq.sv
module tt_irq #(
  parameter int NUM_TMR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TMR-1:0] evt_i,
  input  logic               mask_wr_i,
  input  logic               ack_wr_i,
  input  logic [NUM_TMR-1:0] wdata_i,
  output logic [NUM_TMR-1:0] raw_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic [NUM_TMR-1:0] masked_o,
  output logic               irq_o
);
  logic [NUM_TMR-1:0] raw_q;
  logic [NUM_TMR-1:0] mask_q;
  logic [NUM_TMR-1:0] clr;

  assign clr = ack_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | evt_i;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;

  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !ack_wr_i |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ack_wr_i |=> ((raw_q & $past(wdata_i & ~evt_i)) == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int NUM_TMR  = 2,
  parameter int CNT_W    = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int PS_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  output logic              irq_o
);
  localparam int BLK_W = ADDR_W - 2;
  localparam logic [BLK_W-1:0] GLB_BLK = BLK_W'(NUM_TMR);

  logic [BLK_W-1:0]    blk;
  logic [1:0]          ofs;
  logic [NUM_FREQ-1:0] ticks;
  logic [NUM_TMR-1:0]  evt;
  logic [CNT_W-1:0]    div_a   [NUM_TMR];
  logic [CTRL_W-1:0]   ctrl_a  [NUM_TMR];
  logic [CNT_W-1:0]    count_a [NUM_TMR];
  logic [NUM_TMR-1:0]  raw, mask, masked;
  logic                glb_sel;
  logic [DATA_W-1:0]   rd_mux;

  assign blk     = addr_i[ADDR_W-1:2];
  assign ofs     = addr_i[1:0];
  assign glb_sel = (blk == GLB_BLK);

  tt_prescaler #(.PS_SHIFT(PS_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .tick_o(ticks)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (blk == BLK_W'(g));
    tt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk          (clk),
      .rst          (rst),
      .div_wr_i     (sel && (ofs == OFS_DIV)),
      .div_wdata_i  (wdata_i[CNT_W-1:0]),
      .ctrl_wr_i    (sel && (ofs == OFS_CTRL)),
      .ctrl_wdata_i (wdata_i[CTRL_W-1:0]),
      .tick_i       (ticks),
      .div_o        (div_a[g]),
      .ctrl_o       (ctrl_a[g]),
      .count_o      (count_a[g]),
      .evt_o        (evt[g])
    );
  end

  tt_irq #(.NUM_TMR(NUM_TMR)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .mask_wr_i (wr_en_i && glb_sel && (ofs == GLB_MASK)),
    .ack_wr_i  (wr_en_i && glb_sel && (ofs == GLB_ACK)),
    .wdata_i   (wdata_i[NUM_TMR-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < NUM_TMR; ch++) begin
      if (blk == BLK_W'(ch)) begin
        case (ofs)
          OFS_DIV:   rd_mux = DATA_W'(div_a[ch]);
          OFS_CTRL:  rd_mux = DATA_W'(ctrl_a[ch]);
          OFS_COUNT: rd_mux = DATA_W'(count_a[ch]);
          default:   rd_mux = '0;
        endcase
      end
    end
    if (glb_sel) begin
      case (ofs)
        GLB_MASK:   rd_mux = DATA_W'(mask);
        GLB_RAW:    rd_mux = DATA_W'(raw);
        GLB_MASKED: rd_mux = DATA_W'(masked);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);
  assert_irq_follows_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (evt[0] && mask[0] && !(wr_en_i && glb_sel && (ofs == GLB_MASK))) |=> irq_o);
endmodule

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rd_valid_o(rd_valid), .irq_o(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected read data actual=%0h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'd2, 32'd0, "R1 count after reset");
    rd(4'd9, 32'd0, "R1 raw after reset");
    chk_irq(1'b0, "R1");
    // R2 load without counting
    wr(4'd0, 32'd5);
    wr(4'd1, 32'd1);
    idle(3);
    rd(4'd2, 32'd5, "R2 count after load");
    rd(4'd2, 32'd5, "R2 load does not count");
    wr(4'd8, 32'd1);
    // R3 / R4 run, wrap
    wr(4'd1, 32'd2);
    rd(4'd2, 32'd5, "R3 count 5");
    rd(4'd2, 32'd4, "R3 count 4");
    rd(4'd2, 32'd3, "R3 count 3");
    rd(4'd2, 32'd2, "R3 count 2");
    rd(4'd2, 32'd1, "R3 count 1");
    rd(4'd2, 32'd5, "R4 wrap to period");
    rd(4'd2, 32'd4, "R4 after wrap");
    rd(4'd9, 32'd1, "R7 raw set by reload");
    rd(4'd10, 32'd1, "R9 masked status");
    chk_irq(1'b1, "R9 irq with mask");
    // R5 hold written on a wrap edge: reload completes, then freeze
    wr(4'd1, 32'd0);
    rd(4'd2, 32'd5, "R5 hold after wrap");
    idle(2);
    rd(4'd2, 32'd5, "R5 hold stays");
    // R8 ack
    wr(4'd11, 32'd2);
    rd(4'd9, 32'd1, "R8 zero ack bit no effect");
    wr(4'd11, 32'd1);
    rd(4'd9, 32'd0, "R8 ack clears");
    chk_irq(1'b0, "R8 irq after ack");
    // R8 collision: ack on the reload edge
    wr(4'd0, 32'd3);
    wr(4'd1, 32'd1);
    wr(4'd1, 32'd2);
    idle(2);
    wr(4'd11, 32'd1);
    wr(4'd1, 32'd0);
    rd(4'd9, 32'd1, "R8 ack with event keeps flag");
    rd(4'd2, 32'd2, "R5 held mid period");
    wr(4'd11, 32'd1);
    rd(4'd9, 32'd0, "R8 later ack clears");
    // R6 rate select: code 2 = every 4 cycles, 12 edges -> 3 ticks
    wr(4'd4, 32'd8);
    wr(4'd5, 32'd9);
    wr(4'd5, 32'd10);
    idle(11);
    wr(4'd5, 32'd8);
    rd(4'd6, 32'd5, "R6 three ticks in twelve cycles");
    rd(4'd5, 32'd8, "R10 control readback");
    // R9 mask gating with channel 1
    wr(4'd4, 32'd2);
    wr(4'd5, 32'd1);
    wr(4'd5, 32'd2);
    idle(3);
    wr(4'd5, 32'd0);
    rd(4'd9, 32'd2, "R7 channel 1 raw");
    rd(4'd10, 32'd0, "R9 masked off");
    chk_irq(1'b0, "R9 masked source no irq");
    wr(4'd8, 32'd3);
    rd(4'd10, 32'd2, "R9 masked on");
    chk_irq(1'b1, "R9 irq is OR of masked");
    rd(4'd8, 32'd3, "R10 mask readback");
    idle(3);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing read data actual=%0d expected=0 pending", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule